// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block is the device-side front end of a synchronous burst-read memory interface. The host shares one 16-bit bus between the low address bits and the returned data. It captures a 22-bit word address when chip select and the active-low address-valid strobe are both low at a clock edge. The upper six address bits arrive on their own pins. From that starting word the block steps through a burst of word addresses, one per clock. It presents each address to the storage array and registers the returned word onto the bus.

A small configuration register is loaded by its own write strobe. It holds the burst ordering and the initial latency. The ordering is either a continuous linear count across the whole address space, or a wrap within an aligned block of 8, 16 or 32 words. The initial latency is the number of clocks between the address capture and the first valid word. A ready output tells the host on which clocks the bus carries a fresh word, so the host waits no longer than needed. Raising chip select ends the burst at once. A new address strobe during a burst restarts it from the new address.

Top module: `burst_seq_top`

## Requirements
- R1: At a rising clock edge where `cs_n` and `adr_vld_n` are both low, the start address `{addr_hi, bus_in}` is captured. The first word of the burst is the array word at exactly that address.
- R2: After the capture edge, `burst_ready` stays low until the L-th following rising edge and is high from that edge on. L is the configured latency field; field values 0 and 1 act as 2, and values 2 to 7 are used as given.
- R3: After the first word, `burst_ready` and `bus_oe` stay high on every clock while `cs_n` is low. On each such clock `bus_out` carries the array word of the next address in the burst order.
- R4: Mode code 00 is continuous. The address increments over the full 22-bit space and rolls over from 0x3FFFFF to 0x000000, carrying from bit 15 into bit 16.
- R5: Mode codes 01, 10 and 11 wrap within aligned blocks of 8, 16 and 32 words. Only the low 3, 4 or 5 address bits increment modulo the block size, and the higher bits stay fixed.
- R6: The configuration is loaded only at a rising edge with `cfg_we` high. Mode and latency are taken at the capture edge. A configuration write or input change during a burst does not alter that burst.
- R7: While `cs_n` is high, `burst_ready` and `bus_oe` are low in the same cycle. The burst is ended, and no word is presented after `cs_n` returns low until a new capture.
- R8: A capture during a running burst restarts the sequence from the new address, with the full initial latency.
- R9: Reset clears `burst_ready` and `bus_oe`. It loads the configuration with mode 00 (continuous) and a latency of 4.
- R10: An address strobe while `cs_n` is high captures nothing and starts no burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| adr_vld_n | input | 1 | Active-low address-valid strobe |
| addr_hi | input | 6 | Upper word address bits 21..16 |
| bus_in | input | 16 | Shared bus, input side (low address bits 15..0) |
| bus_out | output | 16 | Shared bus, output side (burst data) |
| bus_oe | output | 1 | Drive enable for the shared bus output |
| burst_ready | output | 1 | High on clocks that present a new burst word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Burst order code for the configuration register |
| cfg_lat | input | 3 | Initial latency field for the configuration register |
| arr_addr | output | 22 | Word address presented to the array |
| arr_data | input | 16 | Word returned combinationally by the array |

## Verification
The properties take for granted that the array answers within the same cycle, so `arr_data` always belongs to the current `arr_addr`. They also assume `cs_n` and the strobe are sampled only at rising edges, with no glitch-level meaning between them. The low-bit step property relies on every burst order moving the lowest three address bits by one each word, which holds for all four codes. The stimulus keeps to these assumptions by changing every input only at the falling clock edge. It models the array as a pure function of the address, and it holds the address on the bus for the whole capture cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int CFG_LAT_W = 3;

  typedef enum logic [1:0] {
    BM_LINEAR = 2'b00,
    BM_WRAP_S = 2'b01,
    BM_WRAP_M = 2'b10,
    BM_WRAP_L = 2'b11
  } burst_mode_e;

  typedef struct packed {
    burst_mode_e          mode;
    logic [CFG_LAT_W-1:0] lat;
  } burst_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_WAIT   = 2'b01,
    ST_STREAM = 2'b10
  } seq_state_e;

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_seq_pkg::*;
#(
  parameter logic [1:0]           RST_MODE = 2'b00,
  parameter logic [CFG_LAT_W-1:0] RST_LAT  = 3'd4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_mode,
  input  logic [CFG_LAT_W-1:0] cfg_lat,
  output burst_cfg_t           cfg_q
);

  burst_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.mode = burst_mode_e'(cfg_mode);
      cfg_d.lat  = cfg_lat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.mode <= burst_mode_e'(RST_MODE);
      cfg_q.lat  <= RST_LAT;
    end else begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next #(
  parameter int ADDR_W       = 22,
  parameter int WRAP_LOG_MIN = 3,
  parameter int N_WRAP       = 3
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] nxt_addr
);

  logic [ADDR_W-1:0] lin_cand;
  logic [ADDR_W-1:0] wrap_cand [N_WRAP];

  assign lin_cand = cur_addr + ADDR_W'(1);

  for (genvar g = 0; g < N_WRAP; g++) begin : g_wrap
    localparam int LG = WRAP_LOG_MIN + g;
    logic [LG-1:0] low_inc;
    assign low_inc      = cur_addr[LG-1:0] + LG'(1);
    assign wrap_cand[g] = {cur_addr[ADDR_W-1:LG], low_inc};
  end

  always_comb begin
    nxt_addr = lin_cand;
    for (int i = 0; i < N_WRAP; i++) begin
      if (int'(mode) == i + 1) nxt_addr = wrap_cand[i];
    end
  end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int MIN_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 adr_vld_n,
  input  logic [ADDR_W-1:0]    start_addr,
  input  burst_cfg_t           cfg,
  input  logic [ADDR_W-1:0]    nxt_addr,
  input  logic [DATA_W-1:0]    arr_data,
  output logic [ADDR_W-1:0]    cur_addr,
  output logic [1:0]           cur_mode,
  output logic [DATA_W-1:0]    data_q,
  output logic                 rdy_q,
  output logic                 oe_q
);

  localparam logic [CFG_LAT_W-1:0] LAT_FLOOR = CFG_LAT_W'(MIN_LAT);

  seq_state_e           state_q, state_d;
  logic [CFG_LAT_W-1:0] cnt_q, cnt_d;
  logic [CFG_LAT_W-1:0] eff_lat;
  logic [1:0]           mode_d;
  logic [ADDR_W-1:0]    addr_d;
  logic                 addr_en, data_en;
  logic                 rdy_d, oe_d;
  logic                 capture;

  assign capture = !cs_n && !adr_vld_n;
  assign eff_lat = (cfg.lat < LAT_FLOOR) ? LAT_FLOOR : cfg.lat;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mode_d  = cur_mode;
    addr_d  = nxt_addr;
    addr_en = 1'b0;
    data_en = 1'b0;
    rdy_d   = rdy_q;
    oe_d    = oe_q;
    if (cs_n) begin
      state_d = ST_IDLE;
      rdy_d   = 1'b0;
      oe_d    = 1'b0;
    end else if (capture) begin
      state_d = ST_WAIT;
      cnt_d   = eff_lat - CFG_LAT_W'(1);
      mode_d  = cfg.mode;
      addr_d  = start_addr;
      addr_en = 1'b1;
      rdy_d   = 1'b0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (cnt_q == '0) begin
            state_d = ST_STREAM;
            addr_en = 1'b1;
            data_en = 1'b1;
            rdy_d   = 1'b1;
            oe_d    = 1'b1;
          end else begin
            cnt_d = cnt_q - CFG_LAT_W'(1);
          end
        end
        ST_STREAM: begin
          addr_en = 1'b1;
          data_en = 1'b1;
          rdy_d   = 1'b1;
          oe_d    = 1'b1;
        end
        default: begin
          rdy_d = 1'b0;
          oe_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      cur_mode <= 2'b00;
      rdy_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      cur_mode <= mode_d;
      rdy_q    <= rdy_d;
      oe_q     <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
    end else if (addr_en) begin
      cur_addr <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= arr_data;
    end
  end

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int MIN_LAT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       adr_vld_n,
  input  logic [ADDR_W-DATA_W-1:0]   addr_hi,
  input  logic [DATA_W-1:0]          bus_in,
  output logic [DATA_W-1:0]          bus_out,
  output logic                       bus_oe,
  output logic                       burst_ready,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_mode,
  input  logic [CFG_LAT_W-1:0]       cfg_lat,
  output logic [ADDR_W-1:0]          arr_addr,
  input  logic [DATA_W-1:0]          arr_data
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic              rst_meta, rst_sync_n;
  burst_cfg_t        cfg_q;
  logic [ADDR_W-1:0] cur_addr, nxt_addr, start_addr;
  logic [1:0]        cur_mode;
  logic [DATA_W-1:0] data_q;
  logic              rdy_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign start_addr = {addr_hi[HI_W-1:0], bus_in};

  burst_cfg_reg #(
    .RST_MODE (2'b00),
    .RST_LAT  (3'd4)
  ) i_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .cfg_lat  (cfg_lat),
    .cfg_q    (cfg_q)
  );

  burst_addr_next #(
    .ADDR_W       (ADDR_W),
    .WRAP_LOG_MIN (3),
    .N_WRAP       (3)
  ) i_next (
    .cur_addr (cur_addr),
    .mode     (cur_mode),
    .nxt_addr (nxt_addr)
  );

  burst_ctrl #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MIN_LAT (MIN_LAT)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cs_n       (cs_n),
    .adr_vld_n  (adr_vld_n),
    .start_addr (start_addr),
    .cfg        (cfg_q),
    .nxt_addr   (nxt_addr),
    .arr_data   (arr_data),
    .cur_addr   (cur_addr),
    .cur_mode   (cur_mode),
    .data_q     (data_q),
    .rdy_q      (rdy_q),
    .oe_q       (oe_q)
  );

  assign arr_addr    = cur_addr;
  assign bus_out     = data_q;
  assign burst_ready = rdy_q & ~cs_n;
  assign bus_oe      = oe_q & ~cs_n;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              adr_vld_n,
  input logic              burst_ready,
  input logic              bus_oe,
  input logic [ADDR_W-1:0] arr_addr
);

  AST_LAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !adr_vld_n) |=> !burst_ready ##1 !burst_ready); // R2

  AST_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_ready && $past(burst_ready)) |->
      (arr_addr[2:0] == $past(arr_addr[2:0]) + 3'd1)); // R3

  AST_READY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    burst_ready |-> bus_oe); // R3

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (!burst_ready && !bus_oe)); // R7

endmodule

bind burst_seq_top burst_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .adr_vld_n   (adr_vld_n),
  .burst_ready (burst_ready),
  .bus_oe      (bus_oe),
  .arr_addr    (arr_addr)
);

// File: tb/test_burst_seq_top.sv
module test_burst_seq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, adr_vld_n, cfg_we;
  logic [5:0]  addr_hi;
  logic [15:0] bus_in, bus_out, arr_data;
  logic [1:0]  cfg_mode;
  logic [2:0]  cfg_lat;
  logic [21:0] arr_addr;
  logic        bus_oe, burst_ready;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [15:0] word_of(logic [21:0] a);
    return a[15:0] ^ {a[21:16], a[21:16], 4'h5};
  endfunction

  assign arr_data = word_of(arr_addr);

  burst_seq_top i_burst_seq_top (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .adr_vld_n (adr_vld_n),
    .addr_hi (addr_hi), .bus_in (bus_in), .bus_out (bus_out),
    .bus_oe (bus_oe), .burst_ready (burst_ready), .cfg_we (cfg_we),
    .cfg_mode (cfg_mode), .cfg_lat (cfg_lat), .arr_addr (arr_addr),
    .arr_data (arr_data)
  );

  // expected successor, written from R4/R5
  function automatic logic [21:0] step(logic [21:0] a, int md);
    logic [21:0] sz;
    if (md == 0) return a + 22'd1;
    sz = 22'd8 << (md - 1);
    return (a & ~(sz - 22'd1)) | ((a + 22'd1) & (sz - 22'd1));
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input int md, input int lat);
    cfg_we = 1'b1; cfg_mode = 2'(md); cfg_lat = 3'(lat);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic end_burst();
    cs_n = 1'b1; adr_vld_n = 1'b1;
    @(negedge clk);
  endtask

  // capture a0, check latency, then n words; leaves the burst running
  task automatic run_burst(input logic [21:0] a0, input int md, input int lat,
                           input int n, input string rq);
    logic [21:0] a;
    a = a0;
    cs_n = 1'b0; adr_vld_n = 1'b0; bus_in = a0[15:0]; addr_hi = a0[21:16];
    @(negedge clk);
    adr_vld_n = 1'b1; bus_in = 16'h0; addr_hi = 6'h0;
    chk(burst_ready === 1'b0, "R2 latency", 32'(burst_ready), 32'd0);
    for (int j = 1; j < lat; j++) begin
      @(negedge clk);
      chk(burst_ready === 1'b0, "R2 latency", 32'(burst_ready), 32'd0);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(burst_ready === 1'b1 && bus_oe === 1'b1 && bus_out === word_of(a),
          (i == 0) ? {"R1 ", rq} : {"R3 ", rq},
          {14'h0, burst_ready, bus_oe, bus_out}, {16'h3, word_of(a)});
      a = step(a, md);
    end
  endtask

  // vector: mode(2) lat(3) start(22) words(6)
  localparam int NV = 5;
  localparam logic [32:0] VECS [NV] = '{
    {2'd0, 3'd2, 22'h3FFFFE, 6'd5},   // R4 rollover
    {2'd1, 3'd3, 22'h012345, 6'd10},  // R5 wrap 8
    {2'd2, 3'd7, 22'h2ABCDE, 6'd18},  // R5 wrap 16
    {2'd3, 3'd5, 22'h00FFFD, 6'd34},  // R5 wrap 32
    {2'd0, 3'd0, 22'h10FFFE, 6'd4}    // R2 floor, R4 carry into bit 16
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; adr_vld_n = 1'b1; cfg_we = 1'b0;
    addr_hi = '0; bus_in = '0; cfg_mode = '0; cfg_lat = '0;
    repeat (3) @(negedge clk);
    chk(burst_ready === 1'b0 && bus_oe === 1'b0, "R9 reset outputs",
        {burst_ready, bus_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: default config is continuous, latency 4
    run_burst(22'h00FFFE, 0, 4, 4, "R9 default");
    end_burst();

    foreach (VECS[v]) begin
      int md, lat, eff, n;
      md  = int'(VECS[v][32:31]);
      lat = int'(VECS[v][30:28]);
      n   = int'(VECS[v][5:0]);
      eff = (lat < 2) ? 2 : lat;
      write_cfg(md, lat);
      run_burst(VECS[v][27:6], md, eff, n, (md == 0) ? "R4" : "R5");
      end_burst();
    end

    // R6: config write during a wrap-8 burst does not change it
    write_cfg(1, 3);
    run_burst(22'h000106, 1, 3, 2, "R6");
    cfg_we = 1'b1; cfg_mode = 2'd0; cfg_lat = 3'd6;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(bus_out === word_of(22'h000100), "R6 mode held", bus_out, word_of(22'h000100));
    @(negedge clk);
    chk(bus_out === word_of(22'h000101), "R6 mode held", bus_out, word_of(22'h000101));
    end_burst();
    // R6: inputs changed without the strobe are not loaded
    cfg_mode = 2'd3; cfg_lat = 3'd3;
    @(negedge clk);
    run_burst(22'h3FFFFF, 0, 6, 3, "R6 no strobe");

    // R7: raising chip select drops ready and drive at once
    cs_n = 1'b1;
    #1;
    chk(burst_ready === 1'b0 && bus_oe === 1'b0, "R7 abort",
        {burst_ready, bus_oe}, 0);
    @(negedge clk);
    cs_n = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(burst_ready === 1'b0 && bus_oe === 1'b0, "R7 stays ended",
          {burst_ready, bus_oe}, 0);
    end

    // R8: capture mid-burst restarts from the new address
    run_burst(22'h000200, 0, 6, 3, "R8 first");
    run_burst(22'h000300, 0, 6, 3, "R8 restart");
    end_burst();

    // R10: strobe with chip select high is ignored
    adr_vld_n = 1'b0; bus_in = 16'h1234;
    repeat (2) @(negedge clk);
    adr_vld_n = 1'b1; cs_n = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(burst_ready === 1'b0 && bus_oe === 1'b0, "R10 ignored strobe",
          {burst_ready, bus_oe}, 0);
    end
    end_burst();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule